// File: doc/BRIEF.md
# Ingress Virtual Output Queue Cell Dispatcher

The block sits at one ingress port of a crossbar fabric built from several independent switching domains. Arriving cell descriptors are sorted into virtual output queues. A unicast descriptor goes to the queue for its egress port and class. A multicast descriptor goes to a per-class queue. Each cycle at most one head-of-line descriptor is chosen and issued on the link of one switching domain. Successive issues rotate over the domains that are currently enabled, so a failed domain drops out of the rotation and its share moves to the others.

Queue choice takes three steps. First a class is picked, by strict priority or by per-class weighted credits, as the configuration selects. Inside that class, unicast and multicast take turns. Unicast egress ports are visited round-robin. A unicast queue whose egress port and class is under backpressure is never picked. A unicast queue that is full raises backpressure toward the line card, and a full multicast queue does the same.

Top module: `voq_ingress_dispatch`

## Requirements
- R1: A unicast descriptor (`in_mc`=0) is queued by egress port and class. A multicast descriptor (`in_mc`=1) is queued by class alone: its egress field is ignored, and it is issued with `link_egr`=0 and `link_mc`=1.
- R2: After reset no link is valid, and all bits of `bp_out` and `mc_bp_out` are 0.
- R3: With `cfg_weighted`=0, class 0 is the most urgent. The lowest-numbered class that has an eligible queue is served.
- R4: Within a class, unicast egress ports are scanned upward, wrapping, starting one past the egress port last served in that class. The scan starts at port 0 after reset.
- R5: Within a class, when both kinds have cells, the kind not served last in that class goes next. Unicast goes first after reset.
- R6: `bp_in` bit egress*NUM_PRI+class blocks that unicast queue until the bit clears. Multicast queues ignore `bp_in`.
- R7: With `cfg_weighted`=1, each class holds a credit. Credits start at 0 after reset. The lowest-numbered eligible class with credit left is served, and its credit drops by one. When no eligible class has credit, every credit is reloaded from `cfg_weight` (WW bits per class, class 0 in the low bits) before the choice is made. A class with weight 0 is not served.
- R8: The issuing domain is the first enabled domain at or above a rotation pointer, wrapping. After each issue the pointer moves to one past that domain. The pointer starts at 0.
- R9: Domains with `dom_en` low are skipped. With no domain enabled nothing is issued, and queued cells are kept.
- R10: `bp_out` bit egress*NUM_PRI+class is high while that unicast queue holds DEPTH descriptors. `mc_bp_out` bit class does the same for the multicast queues.
- R11: A descriptor written to a full queue is discarded.
- R12: A descriptor enqueued at one clock edge can issue at the next edge at the earliest. The outputs are registered, and `link_vld` is one-hot or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor write strobe |
| in_mc | input | 1 | 1 = multicast descriptor |
| in_egr | input | EGW | Egress port (unicast only) |
| in_pri | input | PW | Class, 0 most urgent |
| in_tag | input | TAGW | Descriptor handle |
| cfg_weighted | input | 1 | 0 strict, 1 weighted class choice |
| cfg_weight | input | NUM_PRI*WW | Per-class credit reload values |
| dom_en | input | NUM_DOM | Domain enabled and ready |
| bp_in | input | NUM_EGR*NUM_PRI | Per egress port per class backpressure |
| bp_out | output | NUM_EGR*NUM_PRI | Unicast queue full |
| mc_bp_out | output | NUM_PRI | Multicast queue full |
| link_vld | output | NUM_DOM | Per-domain issue strobe |
| link_mc | output | 1 | Issued descriptor is multicast |
| link_egr | output | EGW | Issued egress port |
| link_pri | output | PW | Issued class |
| link_tag | output | TAGW | Issued handle |

## Verification
The bench builds the block with 4 egress ports, 4 classes, 4 domains, a queue depth of 2, 8-bit handles and 3-bit weights. With a depth of 2, two writes fill a queue, so full-queue backpressure and discarded writes can be reached in a few cycles. With 4 ports and 4 domains, the round-robin pointers wrap inside each short burst. Cells are preloaded while every domain is disabled and are then released, so the whole issue order, including the weighted credit reloads and the unicast/multicast turns, is fixed in advance and compared cell by cell.

// File: rtl/voq_disp_pkg.sv
package voq_disp_pkg;

   typedef enum logic {
      POL_STRICT   = 1'b0,
      POL_WEIGHTED = 1'b1
   } pol_e;

   // wrap-around successor of an index in 0..n-1
   function automatic int wrap_next(input int cur, input int n);
      return (cur >= n - 1) ? 0 : cur + 1;
   endfunction

endpackage

// File: rtl/voq_desc_fifo.sv
module voq_desc_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("voq_desc_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          wr_ok, rd_ok;

   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));
   assign wr_ok = push & ~full;
   assign rd_ok = pop & ~empty;
   assign head  = mem[rp];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (wr_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
         if (rd_ok) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
         cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wp] <= din;
   end

   // R11
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> full);

   // R12
   pop_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> ($past(cnt) != '0) || empty);

endmodule

// File: rtl/voq_rr_pick.sv
module voq_rr_pick #(
   parameter int N  = 8,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] ptr,
   output logic [IW-1:0] idx,
   output logic          any
);

   generate
      if (N < 2) begin : g_bad_n
         $error("voq_rr_pick: N must be at least 2");
      end
   endgenerate

   always_comb begin
      int c;
      any = 1'b0;
      idx = '0;
      for (int k = 0; k < N; k++) begin
         c = int'(ptr) + k;
         if (c >= N) c = c - N;
         if (!any && req[c]) begin
            any = 1'b1;
            idx = IW'(c);
         end
      end
   end

endmodule

// File: rtl/voq_class_arb.sv
module voq_class_arb #(
   parameter int NPRI        = 8,
   parameter int WW          = 4,
   parameter bit WEIGHTED_EN = 1'b1,
   localparam int PW         = $clog2(NPRI)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_w,
   input  logic [NPRI*WW-1:0] weights,
   input  logic [NPRI-1:0]  elig,
   input  logic             go,
   output logic [PW-1:0]    sel,
   output logic             any
);

   generate
      if (NPRI < 2 || WW < 1) begin : g_bad_cfg
         $error("voq_class_arb: NPRI >= 2 and WW >= 1 required");
      end
   endgenerate

   logic [NPRI-1:0] cand;

   // lowest-numbered candidate wins
   always_comb begin
      any = |cand;
      sel = '0;
      for (int p = NPRI - 1; p >= 0; p--) begin
         if (cand[p]) sel = PW'(p);
      end
   end

   generate
      if (WEIGHTED_EN) begin : g_wrr
         logic [WW-1:0]   credit [NPRI];
         logic [WW-1:0]   eff    [NPRI];
         logic [NPRI-1:0] wcand;
         logic            reload;

         always_comb begin
            reload = 1'b1;
            for (int p = 0; p < NPRI; p++) begin
               if (elig[p] && credit[p] != '0) reload = 1'b0;
            end
            for (int p = 0; p < NPRI; p++) begin
               eff[p]   = reload ? weights[p*WW +: WW] : credit[p];
               wcand[p] = elig[p] && (eff[p] != '0);
            end
         end

         assign cand = mode_w ? wcand : elig;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int p = 0; p < NPRI; p++) credit[p] <= '0;
            end else if (go && any && mode_w) begin
               for (int p = 0; p < NPRI; p++) begin
                  credit[p] <= (PW'(p) == sel) ? eff[p] - WW'(1) : eff[p];
               end
            end
         end

         // R7
         wrr_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (go && any && mode_w) |-> (weights[sel*WW +: WW] != '0));
      end else begin : g_strict
         assign cand = elig;
         wire unused_ok = ^{clk, rst_n, mode_w, weights, go};
      end
   endgenerate

   // R3
   strict_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go && any && !mode_w) |-> ((elig & ((NPRI'(1) << sel) - NPRI'(1))) == '0));

endmodule

// File: rtl/voq_ingress_dispatch.sv
module voq_ingress_dispatch
   import voq_disp_pkg::*;
#(
   parameter int NUM_EGR     = 16,
   parameter int NUM_PRI     = 8,
   parameter int NUM_DOM     = 8,
   parameter int DEPTH       = 4,
   parameter int TAGW        = 16,
   parameter int WW          = 4,
   parameter bit WEIGHTED_EN = 1'b1,
   localparam int EGW        = $clog2(NUM_EGR),
   localparam int PW         = $clog2(NUM_PRI),
   localparam int DW         = $clog2(NUM_DOM),
   localparam int NQ         = NUM_EGR * NUM_PRI
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  in_mc,
   input  logic [EGW-1:0]        in_egr,
   input  logic [PW-1:0]         in_pri,
   input  logic [TAGW-1:0]       in_tag,
   input  logic                  cfg_weighted,
   input  logic [NUM_PRI*WW-1:0] cfg_weight,
   input  logic [NUM_DOM-1:0]    dom_en,
   input  logic [NQ-1:0]         bp_in,
   output logic [NQ-1:0]         bp_out,
   output logic [NUM_PRI-1:0]    mc_bp_out,
   output logic [NUM_DOM-1:0]    link_vld,
   output logic                  link_mc,
   output logic [EGW-1:0]        link_egr,
   output logic [PW-1:0]         link_pri,
   output logic [TAGW-1:0]       link_tag
);

   generate
      if (NUM_EGR < 2 || NUM_PRI < 2 || NUM_DOM < 2) begin : g_bad_dims
         $error("voq_ingress_dispatch: port, class and domain counts must be >= 2");
      end
      if (DEPTH < 2 || TAGW < 1) begin : g_bad_store
         $error("voq_ingress_dispatch: DEPTH >= 2 and TAGW >= 1 required");
      end
   endgenerate

   // queue state
   logic [NQ-1:0]      uc_push, uc_pop, uc_empty, uc_full, uc_elig;
   logic [TAGW-1:0]    uc_head [NQ];
   logic [NUM_PRI-1:0] mc_push, mc_pop, mc_empty, mc_full;
   logic [TAGW-1:0]    mc_head [NUM_PRI];

   // per-class selection state
   logic [NUM_PRI-1:0][NUM_EGR-1:0] cls_req;
   logic [EGW-1:0]     uc_ptr [NUM_PRI];
   logic [EGW-1:0]     uc_idx [NUM_PRI];
   logic [NUM_PRI-1:0] uc_any, mc_turn, use_mc, cls_elig;

   // domain rotation and final pick
   logic [DW-1:0]      dptr, dom_idx;
   logic               dom_any, cls_any, fire;
   logic [PW-1:0]      sel_cls;
   logic [TAGW-1:0]    sel_tag;
   logic               sel_mc;
   logic [EGW-1:0]     sel_egr;
   pol_e               policy;

   assign policy  = pol_e'(cfg_weighted);
   assign uc_elig = ~uc_empty & ~bp_in;
   assign bp_out    = uc_full;
   assign mc_bp_out = mc_full;

   // unicast queues, index = egress*NUM_PRI + class
   for (genvar e = 0; e < NUM_EGR; e++) begin : g_egr
      for (genvar p = 0; p < NUM_PRI; p++) begin : g_cls
         localparam int Q = e * NUM_PRI + p;
         assign uc_push[Q] = in_valid & ~in_mc & (in_egr == EGW'(e)) & (in_pri == PW'(p));
         assign uc_pop[Q]  = fire & ~use_mc[p] & (sel_cls == PW'(p)) & (uc_idx[p] == EGW'(e));
         voq_desc_fifo #(.DEPTH(DEPTH), .W(TAGW)) u_q (
            .clk(clk), .rst_n(rst_n), .push(uc_push[Q]), .pop(uc_pop[Q]),
            .din(in_tag), .head(uc_head[Q]), .empty(uc_empty[Q]), .full(uc_full[Q])
         );
      end
   end

   // multicast queues and per-class egress round-robin
   for (genvar p = 0; p < NUM_PRI; p++) begin : g_mc
      assign mc_push[p] = in_valid & in_mc & (in_pri == PW'(p));
      assign mc_pop[p]  = fire & use_mc[p] & (sel_cls == PW'(p));
      voq_desc_fifo #(.DEPTH(DEPTH), .W(TAGW)) u_mq (
         .clk(clk), .rst_n(rst_n), .push(mc_push[p]), .pop(mc_pop[p]),
         .din(in_tag), .head(mc_head[p]), .empty(mc_empty[p]), .full(mc_full[p])
      );
      voq_rr_pick #(.N(NUM_EGR)) u_egr_rr (
         .req(cls_req[p]), .ptr(uc_ptr[p]), .idx(uc_idx[p]), .any(uc_any[p])
      );
      assign cls_elig[p] = uc_any[p] | ~mc_empty[p];
      assign use_mc[p]   = ~mc_empty[p] & (~uc_any[p] | mc_turn[p]);
   end

   always_comb begin
      for (int p = 0; p < NUM_PRI; p++) begin
         for (int e = 0; e < NUM_EGR; e++) begin
            cls_req[p][e] = uc_elig[e * NUM_PRI + p];
         end
      end
   end

   voq_rr_pick #(.N(NUM_DOM)) u_dom_rr (
      .req(dom_en), .ptr(dptr), .idx(dom_idx), .any(dom_any)
   );

   voq_class_arb #(.NPRI(NUM_PRI), .WW(WW), .WEIGHTED_EN(WEIGHTED_EN)) u_cls_arb (
      .clk(clk), .rst_n(rst_n), .mode_w(policy == POL_WEIGHTED), .weights(cfg_weight),
      .elig(cls_elig), .go(dom_any), .sel(sel_cls), .any(cls_any)
   );

   assign fire = dom_any & cls_any;

   always_comb begin
      int qs;
      qs      = int'(uc_idx[sel_cls]) * NUM_PRI + int'(sel_cls);
      sel_mc  = use_mc[sel_cls];
      sel_egr = sel_mc ? '0 : uc_idx[sel_cls];
      sel_tag = sel_mc ? mc_head[sel_cls] : uc_head[qs];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dptr     <= '0;
         link_vld <= '0;
         link_mc  <= 1'b0;
         link_egr <= '0;
         link_pri <= '0;
         link_tag <= '0;
         mc_turn  <= '0;
         for (int p = 0; p < NUM_PRI; p++) uc_ptr[p] <= '0;
      end else begin
         link_vld <= fire ? (NUM_DOM'(1) << dom_idx) : '0;
         if (fire) begin
            link_mc           <= sel_mc;
            link_egr          <= sel_egr;
            link_pri          <= sel_cls;
            link_tag          <= sel_tag;
            dptr              <= DW'(wrap_next(int'(dom_idx), NUM_DOM));
            mc_turn[sel_cls]  <= ~sel_mc;
            if (!sel_mc) uc_ptr[sel_cls] <= EGW'(wrap_next(int'(uc_idx[sel_cls]), NUM_EGR));
         end
      end
   end

   // R9
   no_dom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dom_en == '0) |=> (link_vld == '0));

   // R8
   dom_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (link_vld != '0) |-> ((link_vld & $past(dom_en)) == link_vld));

   // R12
   onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(link_vld));

   // R6
   bp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((uc_pop & bp_in) == '0));

endmodule

// File: tb/voq_ingress_dispatch_tb_top.sv
`timescale 1ns/1ps
module voq_ingress_dispatch_tb_top;

   localparam int NE = 4, NP = 4, ND = 4, DEP = 2, TW = 8, WWB = 3;
   localparam int NQB = NE * NP;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0, in_mc = 1'b0;
   logic [1:0]      in_egr = '0, in_pri = '0;
   logic [TW-1:0]   in_tag = '0;
   logic            cfg_weighted = 1'b0;
   logic [NP*WWB-1:0] cfg_weight = '0;
   logic [ND-1:0]   dom_en = '0;
   logic [NQB-1:0]  bp_in = '0;
   logic [NQB-1:0]  bp_out;
   logic [NP-1:0]   mc_bp_out;
   logic [ND-1:0]   link_vld;
   logic            link_mc;
   logic [1:0]      link_egr, link_pri;
   logic [TW-1:0]   link_tag;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   typedef struct packed {
      logic [7:0] req;
      logic [7:0] tag;
      logic [1:0] dom;
      logic       mc;
      logic [1:0] egr;
      logic [1:0] pri;
   } exp_t;
   exp_t exp_q [$];

   always #2 clk = ~clk;

   voq_ingress_dispatch #(
      .NUM_EGR(NE), .NUM_PRI(NP), .NUM_DOM(ND), .DEPTH(DEP), .TAGW(TW), .WW(WWB)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mc(in_mc), .in_egr(in_egr),
      .in_pri(in_pri), .in_tag(in_tag), .cfg_weighted(cfg_weighted), .cfg_weight(cfg_weight),
      .dom_en(dom_en), .bp_in(bp_in), .bp_out(bp_out), .mc_bp_out(mc_bp_out),
      .link_vld(link_vld), .link_mc(link_mc), .link_egr(link_egr), .link_pri(link_pri),
      .link_tag(link_tag)
   );

   task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   task automatic enq(input bit mc, input int egr, input int pri, input int tag);
      @(negedge clk);
      in_valid = 1'b1; in_mc = mc; in_egr = 2'(egr); in_pri = 2'(pri); in_tag = 8'(tag);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_cell(input int req, input int tag, input int dom, input bit mc,
                              input int egr, input int pri);
      exp_t x;
      x.req = 8'(req); x.tag = 8'(tag); x.dom = 2'(dom); x.mc = mc;
      x.egr = 2'(egr); x.pri = 2'(pri);
      exp_q.push_back(x);
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   // monitor: every issued cell is compared with the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n && link_vld != '0) begin
         if (exp_q.size() == 0) begin
            check("R9/R11 unexpected issue", 1'b0, {24'd0, link_tag}, 32'd0);
         end else begin
            exp_t x;
            logic [ND-1:0] ev;
            x  = exp_q.pop_front();
            ev = ND'(1) << x.dom;
            check($sformatf("R%0d issue of tag %0h", x.req, x.tag),
                  link_vld == ev && link_tag == x.tag && link_mc == x.mc &&
                  link_egr == x.egr && link_pri == x.pri,
                  {link_vld, link_tag, 3'd0, link_mc, link_egr, link_pri},
                  {ev, x.tag, 3'd0, x.mc, x.egr, x.pri});
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      check("R2 link_vld", link_vld == '0, 32'(link_vld), 0);
      check("R2 bp outputs", bp_out == '0 && mc_bp_out == '0, {bp_out, 12'd0, mc_bp_out}, 0);

      // S1: R3 strict order, R4 egress round-robin, R8 rotation, R9 hold while disabled
      enq(0, 0, 2, 8'h10);
      enq(0, 1, 0, 8'h11);
      enq(0, 0, 0, 8'h12);
      repeat (3) @(negedge clk);
      check("R9 no issue with all domains off", link_vld == '0, 32'(link_vld), 0);
      expect_cell(3, 8'h12, 0, 0, 0, 0);
      expect_cell(4, 8'h11, 1, 0, 1, 0);
      expect_cell(3, 8'h10, 2, 0, 0, 2);
      dom_en = 4'b1111;
      drain();

      // S2: R9 disabled domains skipped, R10 full unicast queue, R4 wrap
      dom_en = 4'b0000;
      enq(0, 2, 1, 8'h20);
      enq(0, 2, 1, 8'h21);
      enq(0, 3, 1, 8'h22);
      check("R10 bp_out bit 9 on full queue", bp_out == 16'h0200, 32'(bp_out), 32'h0200);
      expect_cell(9, 8'h20, 0, 0, 2, 1);
      expect_cell(4, 8'h22, 2, 0, 3, 1);
      expect_cell(8, 8'h21, 0, 0, 2, 1);
      dom_en = 4'b0101;
      drain();
      check("R10 bp_out clears after drain", bp_out == '0, 32'(bp_out), 0);

      // S3: R6 backpressure on egress 1 class 0 (bit 4)
      dom_en = 4'b0000;
      bp_in = 16'h0010;
      enq(0, 1, 0, 8'h30);
      enq(0, 1, 3, 8'h31);
      expect_cell(6, 8'h31, 1, 0, 1, 3);
      dom_en = 4'b1111;
      drain();
      repeat (4) begin
         @(negedge clk);
         check("R6 blocked queue stays quiet", link_vld == '0, 32'(link_vld), 0);
      end
      expect_cell(6, 8'h30, 2, 0, 1, 0);
      bp_in = '0;
      drain();

      // S4: R5 unicast/multicast alternation, R1 multicast ignores egress, R10 mc full
      dom_en = 4'b0000;
      enq(0, 0, 2, 8'h40);
      enq(0, 3, 2, 8'h41);
      enq(1, 3, 2, 8'h42);
      enq(1, 1, 2, 8'h43);
      check("R10 mc_bp_out bit 2", mc_bp_out == 4'b0100, 32'(mc_bp_out), 32'h4);
      expect_cell(5, 8'h42, 3, 1, 0, 2);
      expect_cell(5, 8'h41, 0, 0, 3, 2);
      expect_cell(1, 8'h43, 1, 1, 0, 2);
      expect_cell(5, 8'h40, 2, 0, 0, 2);
      dom_en = 4'b1111;
      drain();

      // S5: R7 weighted credits, class 0 weight 2, others 1
      dom_en = 4'b0000;
      cfg_weighted = 1'b1;
      cfg_weight = {3'd1, 3'd1, 3'd1, 3'd2};
      enq(0, 0, 0, 8'h50);
      enq(0, 0, 0, 8'h51);
      enq(0, 1, 0, 8'h52);
      enq(0, 1, 0, 8'h53);
      enq(0, 0, 1, 8'h54);
      enq(0, 0, 1, 8'h55);
      expect_cell(7, 8'h50, 3, 0, 0, 0);
      expect_cell(7, 8'h52, 0, 0, 1, 0);
      expect_cell(7, 8'h54, 1, 0, 0, 1);
      expect_cell(7, 8'h51, 2, 0, 0, 0);
      expect_cell(7, 8'h53, 3, 0, 1, 0);
      expect_cell(7, 8'h55, 0, 0, 0, 1);
      dom_en = 4'b1111;
      drain();

      // S6: R11 third write to a depth-2 queue is discarded
      dom_en = 4'b0000;
      cfg_weighted = 1'b0;
      enq(0, 3, 3, 8'h60);
      enq(0, 3, 3, 8'h61);
      enq(0, 3, 3, 8'h62);
      expect_cell(11, 8'h60, 1, 0, 3, 3);
      expect_cell(11, 8'h61, 2, 0, 3, 3);
      dom_en = 4'b1111;
      drain();
      repeat (6) @(negedge clk);
      check("R11 queue empty after two issues", bp_out == '0 && link_vld == '0,
            {bp_out, 12'd0, link_vld}, 0);
      check("R12 scoreboard drained", exp_q.size() == 0, 32'(exp_q.size()), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule